// File: doc/BRIEF.md
# Extended Audio Control and Sample-Rate Register File

This block holds the extended-audio control word of an audio codec together with the five sample-rate registers for its converter groups. Software reaches it through a simple register-access port: a word index, write data with a write strobe, and a read strobe that loads a registered read-data output. The block decodes the control bits and sends them to the rest of the codec. These bits are the variable-rate enables for the PCM converters and for the microphone ADC, a double-rate enable, and an S/PDIF transmitter enable with its link slot-pair code. The block also outputs a 17-bit effective sample rate for each converter group.

A rate register can be changed only while the variable-rate enable that governs it is set. While that enable is clear, the register is pinned to the 48 kHz code and any value written to it is lost. A double-rate enable raises the three DAC groups to twice their programmed rate, or to a fixed 96 kHz when variable rate is off. The slot-pair field refuses the 10&11 code when a build option leaves it out. Software can therefore find out whether 10&11 is supported by writing that code and reading it back.

Top module: `acx_regfile`

## Requirements
- R1: After the asynchronous active-low reset, the control word bits 5:0 read as {SLOT_DEFAULT, 4'b0000}, and every rate register (indexes 2Ch, 2Eh, 30h, 32h, 34h) reads BB80h. All enables are 0, the slot output equals SLOT_DEFAULT (default 01b), and rdata_o is 0000h.
- R2: A write to index 2Ah stores bit 0 as the PCM variable-rate enable, bit 1 as double-rate, bit 2 as S/PDIF enable and bit 3 as the mic variable-rate enable. Each appears on its output port and reads back in the same bit position.
- R3: Bits 15:6 of a read of index 2Ah return stat_i as sampled in the read cycle. Write data on those bits has no effect.
- R4: While the PCM variable-rate enable is 0, the PCM rate registers (2Ch front DAC, 2Eh surround DAC, 30h LFE DAC, 32h PCM ADC) stay at BB80h and writes to them are discarded. While it is 1, a write stores the full 16-bit value.
- R5: A control write that clears a variable-rate enable sets the rate registers it governs to BB80h on the same clock edge. Their earlier values are not restored when the enable is set again.
- R6: The mic rate register at 34h obeys the rules of R4 and R5 under the mic variable-rate enable (bit 3), independently of bit 0.
- R7: With double-rate on and PCM variable-rate off, the front, surround and LFE effective rates are 96000. The ADC and mic effective rates stay equal to their registers.
- R8: With double-rate and PCM variable-rate both on, each DAC effective rate is twice its register. With double-rate off, every effective rate equals its register zero-extended to 17 bits.
- R9: Slot codes 00b (3&4), 01b (7&8) and 10b (6&9) written to bits 5:4 are always stored. Code 11b (10&11) is stored only when SLOT_1011_EN is 1; otherwise the field keeps its previous code.
- R10: A read of any index other than 2Ah, 2Ch, 2Eh, 30h, 32h or 34h returns 0000h, and a write to such an index changes no register.
- R11: rdata_o takes the addressed value on the clock edge that samples rd_i high, and holds its value on every edge where rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 7 | Register index |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| stat_i | input | 10 | Read-only status bits shown at 15:6 of the control word |
| rdata_o | output | 16 | Registered read data |
| vra_o | output | 1 | PCM variable-rate enable |
| dra_o | output | 1 | Double-rate enable |
| spdif_en_o | output | 1 | S/PDIF transmitter enable (0 = powered down) |
| vrm_o | output | 1 | Mic variable-rate enable |
| slot_sel_o | output | 2 | S/PDIF slot-pair code |
| front_rate_o | output | 17 | Effective front DAC rate |
| surr_rate_o | output | 17 | Effective surround DAC rate |
| lfe_rate_o | output | 17 | Effective LFE DAC rate |
| adc_rate_o | output | 17 | Effective PCM ADC rate |
| mic_rate_o | output | 17 | Effective mic ADC rate |

## Verification
The assertions take for granted that the access port is synchronous to clk_i and that every strobe and index is a known value at each edge. They also assume stat_i is a plain level, sampled in the same cycle as the read. The stimulus changes inputs only on falling edges and issues a single access per cycle, never a read and a write together. The random phase is limited to the implemented indexes plus their odd and neighbouring addresses. This keeps the pinning rules, the 11b slot rejection and the zero readback covered without drifting into index ranges that the properties do not describe.

// File: rtl/acx_pkg.sv
package acx_pkg;
    localparam int IDX_W      = 7;
    localparam int DATA_W     = 16;
    localparam int CTRL_BITS  = 6;
    localparam int N_RATE     = 5;
    localparam int N_PCM      = 4;
    localparam int N_DAC      = 3;
    localparam logic [DATA_W-1:0] RATE_48K = 16'hBB80;
    localparam int RATE_96K   = 96000;

    typedef struct packed {
        logic [1:0] slot;
        logic       vrm;
        logic       spdif;
        logic       dra;
        logic       vra;
    } ctrl_t;
endpackage

// File: rtl/acx_slot_gate.sv
module acx_slot_gate #(
    parameter bit ALLOW_1011 = 1'b0
) (
    input  logic [1:0] req_i,
    input  logic [1:0] cur_i,
    output logic [1:0] next_o
);
    always_comb begin
        if (req_i == 2'b11 && !ALLOW_1011) begin
            next_o = cur_i;
        end else begin
            next_o = req_i;
        end
    end
endmodule

// File: rtl/acx_rate_cell.sv
module acx_rate_cell #(
    parameter int              W   = 16,
    parameter logic [W-1:0]    DEF = 16'hBB80
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         pin_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rate_o
);
    logic [W-1:0] rate_d, rate_q;

    always_comb begin
        rate_d = rate_q;
        if (pin_i) begin
            rate_d = DEF;
        end else if (wr_i) begin
            rate_d = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rate_q <= DEF;
        end else begin
            rate_q <= rate_d;
        end
    end

    assign rate_o = rate_q;
endmodule

// File: rtl/acx_rate_scale.sv
module acx_rate_scale #(
    parameter int W      = 16,
    parameter int EW     = 17,
    parameter bit IS_DAC = 1'b1,
    parameter int FIXED  = 96000
) (
    input  logic [W-1:0]  rate_i,
    input  logic          vra_i,
    input  logic          dra_i,
    output logic [EW-1:0] eff_o
);
    generate
        if (IS_DAC) begin : g_dac
            always_comb begin
                if (dra_i) begin
                    eff_o = vra_i ? EW'({rate_i, 1'b0}) : EW'(FIXED);
                end else begin
                    eff_o = EW'(rate_i);
                end
            end
        end else begin : g_pass
            logic unused_en;
            assign unused_en = vra_i ^ dra_i;
            assign eff_o = EW'(rate_i);
        end
    endgenerate
endmodule

// File: rtl/acx_regfile.sv
module acx_regfile
    import acx_pkg::*;
#(
    parameter int         CTRL_INDEX   = 'h2A,
    parameter int         RATE_BASE    = 'h2C,
    parameter int         RATE_STEP    = 2,
    parameter logic [1:0] SLOT_DEFAULT = 2'b01,
    parameter bit         SLOT_1011_EN = 1'b0,
    localparam int        STAT_W       = DATA_W - CTRL_BITS,
    localparam int        EFF_W        = DATA_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              vra_o,
    output logic              dra_o,
    output logic              spdif_en_o,
    output logic              vrm_o,
    output logic [1:0]        slot_sel_o,
    output logic [EFF_W-1:0]  front_rate_o,
    output logic [EFF_W-1:0]  surr_rate_o,
    output logic [EFF_W-1:0]  lfe_rate_o,
    output logic [EFF_W-1:0]  adc_rate_o,
    output logic [EFF_W-1:0]  mic_rate_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] rdata;
    } state_t;

    localparam ctrl_t CTRL_RST = '{slot: SLOT_DEFAULT, vrm: 1'b0, spdif: 1'b0,
                                   dra: 1'b0, vra: 1'b0};

    state_t            st_d, st_q;
    logic [1:0]        slot_next;
    logic              ctrl_wr;
    logic [DATA_W-1:0] rate_q [N_RATE];
    logic [EFF_W-1:0]  eff    [N_RATE];
    logic [N_RATE-1:0] rate_hit;

    assign ctrl_wr = wr_i && (idx_i == IDX_W'(CTRL_INDEX));

    acx_slot_gate #(.ALLOW_1011(SLOT_1011_EN)) slot_gate_i (
        .req_i  (wdata_i[5:4]),
        .cur_i  (st_q.ctrl.slot),
        .next_o (slot_next)
    );

    always_comb begin
        logic [DATA_W-1:0] rd_val;
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl.vra   = wdata_i[0];
            st_d.ctrl.dra   = wdata_i[1];
            st_d.ctrl.spdif = wdata_i[2];
            st_d.ctrl.vrm   = wdata_i[3];
            st_d.ctrl.slot  = slot_next;
        end
        rd_val = '0;
        if (idx_i == IDX_W'(CTRL_INDEX)) begin
            rd_val = {stat_i, st_q.ctrl};
        end
        for (int k = 0; k < N_RATE; k++) begin
            if (idx_i == IDX_W'(RATE_BASE + RATE_STEP * k)) begin
                rd_val = rate_q[k];
            end
        end
        if (rd_i) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ctrl: CTRL_RST, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar k = 0; k < N_RATE; k++) begin : g_rate
            logic pin;
            assign rate_hit[k] = wr_i && (idx_i == IDX_W'(RATE_BASE + RATE_STEP * k));
            if (k < N_PCM) begin : g_pcm
                assign pin = !st_d.ctrl.vra;
            end else begin : g_mic
                assign pin = !st_d.ctrl.vrm;
            end

            acx_rate_cell #(.W(DATA_W), .DEF(RATE_48K)) cell_i (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .pin_i   (pin),
                .wr_i    (rate_hit[k]),
                .wdata_i (wdata_i),
                .rate_o  (rate_q[k])
            );

            acx_rate_scale #(
                .W(DATA_W), .EW(EFF_W), .IS_DAC(k < N_DAC), .FIXED(RATE_96K)
            ) scale_i (
                .rate_i (rate_q[k]),
                .vra_i  (st_q.ctrl.vra),
                .dra_i  (st_q.ctrl.dra),
                .eff_o  (eff[k])
            );
        end
    endgenerate

    assign rdata_o      = st_q.rdata;
    assign vra_o        = st_q.ctrl.vra;
    assign dra_o        = st_q.ctrl.dra;
    assign spdif_en_o   = st_q.ctrl.spdif;
    assign vrm_o        = st_q.ctrl.vrm;
    assign slot_sel_o   = st_q.ctrl.slot;
    assign front_rate_o = eff[0];
    assign surr_rate_o  = eff[1];
    assign lfe_rate_o   = eff[2];
    assign adc_rate_o   = eff[3];
    assign mic_rate_o   = eff[4];
endmodule

// File: rtl/acx_regfile_chk.sv
module acx_regfile_chk #(
    parameter int IDX_W        = 7,
    parameter int DATA_W       = 16,
    parameter int STAT_W       = 10,
    parameter int EFF_W        = 17,
    parameter int CTRL_INDEX   = 'h2A,
    parameter bit SLOT_1011_EN = 1'b0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [IDX_W-1:0]  idx_i,
    input logic              rd_i,
    input logic [STAT_W-1:0] stat_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              vra_o,
    input logic              dra_o,
    input logic              vrm_o,
    input logic [1:0]        slot_sel_o,
    input logic [EFF_W-1:0]  front_rate_o,
    input logic [EFF_W-1:0]  surr_rate_o,
    input logic [EFF_W-1:0]  lfe_rate_o,
    input logic [EFF_W-1:0]  adc_rate_o,
    input logic [EFF_W-1:0]  mic_rate_o
);
    // R4
    adc_pinned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vra_o |-> adc_rate_o == EFF_W'(16'hBB80));

    // R6
    mic_pinned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vrm_o |-> mic_rate_o == EFF_W'(16'hBB80));

    // R7
    fixed_double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dra_o && !vra_o) |-> (front_rate_o == EFF_W'(96000)
                               && surr_rate_o == EFF_W'(96000)
                               && lfe_rate_o == EFF_W'(96000)));

    // R8
    doubled_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dra_o && vra_o) |-> (front_rate_o[0] == 1'b0 && surr_rate_o[0] == 1'b0
                              && lfe_rate_o[0] == 1'b0));

    // R9
    slot_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !SLOT_1011_EN |-> slot_sel_o != 2'b11);

    // R3
    status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && idx_i == IDX_W'(CTRL_INDEX)) |=> rdata_o[DATA_W-1:DATA_W-STAT_W] == $past(stat_i));

    // R11
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o));
endmodule

bind acx_regfile acx_regfile_chk #(
    .IDX_W(acx_pkg::IDX_W), .DATA_W(acx_pkg::DATA_W), .STAT_W(STAT_W), .EFF_W(EFF_W),
    .CTRL_INDEX(CTRL_INDEX), .SLOT_1011_EN(SLOT_1011_EN)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(idx_i), .rd_i(rd_i), .stat_i(stat_i),
    .rdata_o(rdata_o), .vra_o(vra_o), .dra_o(dra_o), .vrm_o(vrm_o),
    .slot_sel_o(slot_sel_o), .front_rate_o(front_rate_o), .surr_rate_o(surr_rate_o),
    .lfe_rate_o(lfe_rate_o), .adc_rate_o(adc_rate_o), .mic_rate_o(mic_rate_o)
);

// File: tb/acx_regfile_tb.sv
`timescale 1ns/1ps
module acx_regfile_tb_top;
    localparam bit         EN1011 = 1'b0;
    localparam logic [1:0] SLDEF  = 2'b01;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [6:0]  idx_i = '0;
    logic [15:0] wdata_i = '0;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [9:0]  stat_i = '0;
    logic [15:0] rdata_o;
    logic        vra_o, dra_o, spdif_en_o, vrm_o;
    logic [1:0]  slot_sel_o;
    logic [16:0] front_rate_o, surr_rate_o, lfe_rate_o, adc_rate_o, mic_rate_o;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic        m_vra = 0, m_dra = 0, m_spdif = 0, m_vrm = 0;
    logic [1:0]  m_slot = SLDEF;
    logic [15:0] m_rate [5] = '{16'hBB80, 16'hBB80, 16'hBB80, 16'hBB80, 16'hBB80};

    always #2.5 clk_i = ~clk_i;

    acx_regfile #(.SLOT_DEFAULT(SLDEF), .SLOT_1011_EN(EN1011)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(idx_i), .wdata_i(wdata_i),
        .wr_i(wr_i), .rd_i(rd_i), .stat_i(stat_i), .rdata_o(rdata_o),
        .vra_o(vra_o), .dra_o(dra_o), .spdif_en_o(spdif_en_o), .vrm_o(vrm_o),
        .slot_sel_o(slot_sel_o), .front_rate_o(front_rate_o), .surr_rate_o(surr_rate_o),
        .lfe_rate_o(lfe_rate_o), .adc_rate_o(adc_rate_o), .mic_rate_o(mic_rate_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] eff_exp(int k);
        if (k < 3 && m_dra) return m_vra ? {m_rate[k], 1'b0} : 17'd96000;
        return {1'b0, m_rate[k]};
    endfunction

    function automatic logic [15:0] rd_exp(logic [6:0] idx);
        if (idx == 7'h2A) return {stat_i, m_slot, m_vrm, m_spdif, m_dra, m_vra};
        for (int k = 0; k < 5; k++)
            if (idx == 7'(7'h2C + 2 * k)) return m_rate[k];
        return 16'h0000;
    endfunction

    function automatic void model_wr(logic [6:0] idx, logic [15:0] d);
        if (idx == 7'h2A) begin
            m_vra = d[0]; m_dra = d[1]; m_spdif = d[2]; m_vrm = d[3];
            if (d[5:4] != 2'b11 || EN1011) m_slot = d[5:4];
            if (!m_vra) for (int k = 0; k < 4; k++) m_rate[k] = 16'hBB80;
            if (!m_vrm) m_rate[4] = 16'hBB80;
        end else begin
            for (int k = 0; k < 4; k++)
                if (idx == 7'(7'h2C + 2 * k) && m_vra) m_rate[k] = d;
            if (idx == 7'h34 && m_vrm) m_rate[4] = d;
        end
    endfunction

    task automatic do_wr(input logic [6:0] idx, input logic [15:0] d);
        @(negedge clk_i);
        idx_i = idx; wdata_i = d; wr_i = 1'b1;
        @(negedge clk_i);
        wr_i = 1'b0;
        model_wr(idx, d);
    endtask

    task automatic do_rd(input logic [6:0] idx, input string tag);
        logic [15:0] e;
        @(negedge clk_i);
        idx_i = idx; rd_i = 1'b1;
        e = rd_exp(idx);
        @(negedge clk_i);
        rd_i = 1'b0;
        chk(rdata_o == e, tag, 32'(rdata_o), 32'(e));
    endtask

    task automatic chk_outs(input string tag);
        logic [16:0] e [5];
        for (int k = 0; k < 5; k++) e[k] = eff_exp(k);
        chk({vra_o, dra_o, spdif_en_o, vrm_o, slot_sel_o} ==
            {m_vra, m_dra, m_spdif, m_vrm, m_slot}, {tag, " ctrl"},
            32'({vra_o, dra_o, spdif_en_o, vrm_o, slot_sel_o}),
            32'({m_vra, m_dra, m_spdif, m_vrm, m_slot}));
        chk(front_rate_o == e[0], {tag, " front"}, 32'(front_rate_o), 32'(e[0]));
        chk(surr_rate_o == e[1], {tag, " surr"}, 32'(surr_rate_o), 32'(e[1]));
        chk(lfe_rate_o == e[2], {tag, " lfe"}, 32'(lfe_rate_o), 32'(e[2]));
        chk(adc_rate_o == e[3], {tag, " adc"}, 32'(adc_rate_o), 32'(e[3]));
        chk(mic_rate_o == e[4], {tag, " mic"}, 32'(mic_rate_o), 32'(e[4]));
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] hold;
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1 reset state
        chk(rdata_o == 16'h0, "R1 rdata", 32'(rdata_o), 32'h0);
        chk_outs("R1 reset");
        do_rd(7'h2A, "R1 ctrl");
        for (int k = 0; k < 5; k++) do_rd(7'(7'h2C + 2 * k), "R1 rate");

        // R4 writes discarded while vra=0
        do_wr(7'h2C, 16'h1234);
        do_wr(7'h32, 16'h5622);
        do_rd(7'h2C, "R4 front pinned");
        do_rd(7'h32, "R4 adc pinned");
        chk_outs("R4 pinned");

        // R2 control bits, R4 writes accepted
        do_wr(7'h2A, 16'h0001);
        chk_outs("R2 vra on");
        do_wr(7'h2C, 16'hAC44);
        do_wr(7'h2E, 16'h5622);
        do_wr(7'h30, 16'h7D00);
        do_wr(7'h32, 16'h3E80);
        do_rd(7'h2E, "R4 surr stored");
        do_rd(7'h32, "R4 adc stored");
        do_wr(7'h2A, 16'h0005);
        do_rd(7'h2A, "R2 spdif bit");
        chk_outs("R2 spdif");

        // R8 doubled
        do_wr(7'h2A, 16'h0003);
        chk_outs("R8 dra+vra");
        // R7 fixed 96k, rates pinned by clearing vra
        do_wr(7'h2A, 16'h0002);
        chk(front_rate_o == 17'd96000, "R7 front", 32'(front_rate_o), 32'd96000);
        chk(adc_rate_o == 17'h0BB80, "R7 adc", 32'(adc_rate_o), 32'hBB80);
        chk_outs("R7 dra only");

        // R5 values lost after clear
        do_wr(7'h2A, 16'h0001);
        do_rd(7'h2C, "R5 front lost");
        do_rd(7'h30, "R5 lfe lost");

        // R6 mic under vrm
        do_wr(7'h34, 16'h1F40);
        do_rd(7'h34, "R6 mic pinned");
        do_wr(7'h2A, 16'h0008);
        do_wr(7'h34, 16'h1F40);
        do_rd(7'h34, "R6 mic stored");
        do_wr(7'h2A, 16'h0009);
        do_rd(7'h34, "R6 mic kept");
        do_wr(7'h2A, 16'h0001);
        do_rd(7'h34, "R6 mic lost");
        chk_outs("R6");

        // R9 slot codes
        for (int c = 0; c < 4; c++) begin
            do_wr(7'h2A, 16'(c << 4));
            do_rd(7'h2A, "R9 slot");
            chk(slot_sel_o == m_slot, "R9 slot out", 32'(slot_sel_o), 32'(m_slot));
        end

        // R3 status passthrough, status write ignored
        stat_i = 10'h2A5;
        do_wr(7'h2A, 16'hFFC1);
        do_rd(7'h2A, "R3 status");
        stat_i = 10'h15A;
        do_rd(7'h2A, "R3 status change");

        // R10 unimplemented indexes
        do_wr(7'h2C, 16'h4321);
        do_wr(7'h2D, 16'h9999);
        do_wr(7'h36, 16'h9999);
        do_rd(7'h2D, "R10 odd idx");
        do_rd(7'h00, "R10 idx 0");
        do_rd(7'h2C, "R10 neighbour unchanged");
        chk_outs("R10");

        // R11 hold between reads
        do_rd(7'h2C, "R11 load");
        hold = rdata_o;
        do_wr(7'h2C, 16'h0101);
        repeat (3) @(negedge clk_i);
        chk(rdata_o == hold, "R11 hold", 32'(rdata_o), 32'(hold));

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [6:0]  ri;
            logic [15:0] rdv;
            ri = 7'(7'h29 + ($urandom % 14));
            rdv = 16'($urandom);
            stat_i = 10'($urandom);
            case ($urandom % 4)
                0: do_wr(7'h2A, rdv);
                1: do_wr(ri, rdv);
                default: do_rd(ri, "R4 R5 R9 R10 random read");
            endcase
            chk_outs("R7 R8 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule